// File: doc/BRIEF.md
# Dual-Port Mailbox Control Register

This block holds one byte of control and status that two masters share. The local CPU reads and writes the whole byte through a simple port. A remote master reaches the byte through a VME-style slave port, where it serves as a mailbox. When the remote side sets the pending flag, the block raises a level-5 interrupt toward the local CPU. The CPU handles the event and clears the flag by writing the byte.

The remote port works from a single cycle strobe. On the strobe's first cycle, the address decoder checks whether the access falls inside the register's alias range. That range is every odd byte in the lowest 8 KB of the 1 MB window that the base field selects. An access inside the range is then handled as one of three operations:
- a read, which returns the byte;
- a write, which can only set the pending flag;
- a test-and-set, which returns the old byte and sets the flag in the same clock.

A bus-cycle watchdog watches every remote strobe while its enable bit is set. It emits a one-cycle bus-error pulse if the cycle goes 128 µs without an acknowledge.

A hardware reset loads a value that depends on the slot-1 strap. A software reset loads a value built from the strap and from a preset byte, which a non-volatile store supplies outside this block.

Bit layout (the decoder and the interrupt depend on it):
- bit 7: pending flag
- bit 6: window enable
- bit 5: watchdog enable
- bit 4: system-controller flag
- bits 3..0: window base, which is compared with address bits 23..20

The remote port is controlled by a state machine with states V_IDLE, V_READ, V_WRITE, V_TAS, V_HOLD and V_SKIP. Its transitions are:
- V_IDLE goes to V_READ, V_WRITE or V_TAS on a strobe that hits the range.
- V_IDLE goes to V_SKIP on a strobe that misses the range.
- V_READ, V_WRITE and V_TAS each go to V_HOLD after one clock. V_HOLD drives the acknowledge.
- V_HOLD and V_SKIP return to V_IDLE when the strobe drops.

The watchdog has states T_IDLE, T_RUN and T_FIRED:
- Any new strobe while the watchdog is enabled moves it to T_RUN with the count at zero.
- T_RUN goes to T_IDLE on an acknowledge, on a dropped strobe, or when the watchdog is disabled.
- T_RUN goes to T_FIRED when the limit is reached, and the bus-error pulse is emitted at that point.
- T_FIRED goes to T_IDLE when the strobe drops.

Top module: `mbox_ctl_reg`

## Requirements
- R1: On hardware reset (rst_n low) the byte is 0x10 when slot1_i is 1 and 0x00 when slot1_i is 0.
- R2: A software reset pulse (sw_rst high for one clock) loads the byte as follows: bit 7 becomes 0, bits 5 and 4 both take slot1_i, bit 6 takes preset_i[6], and bits 3..0 take preset_i[3:0].
- R3: A CPU write (cpu_wr high for one clock) loads all 8 bits from cpu_wdata, and cpu_rdata always shows the current byte.
- R4: irq5_o is high exactly while bit 7 of the byte is 1.
- R5: A remote strobe is acknowledged (vme_ack goes high) only when all of these hold: bit 6 is 1, vme_addr[23:20] equals bits 3..0, vme_addr[19:13] are all zero, and vme_addr[0] is 1. Any other address gets no acknowledge.
- R6: A remote write sets bit 7 when vme_wdata[7] is 1. It never clears bit 7 and never changes bits 6..0.
- R7: A remote read at any odd address in the alias range returns the current byte on vme_rdata while vme_ack is high.
- R8: A remote test-and-set (vme_tas high during the strobe) returns the byte as it was before the access and leaves bit 7 set.
- R9: When a remote set of bit 7 and a CPU write with cpu_wdata[7] = 0 take effect in the same clock, bit 7 ends as 1. The CPU still loads bits 6..0.
- R10: While bit 5 is 1, a remote strobe held high without an acknowledge for 6400 clocks (128 µs at 50 MHz) produces exactly one single-clock pulse on berr_o. A cycle that is acknowledged in time produces no pulse, and no pulse occurs while bit 5 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset pulse |
| slot1_i | input | 1 | Strap that is high when the board sits in the first slot |
| preset_i | input | 8 | Preset byte for software reset; bits 6 and 3..0 are used |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Current register byte |
| vme_stb | input | 1 | Remote cycle strobe, held for the whole cycle |
| vme_addr | input | 24 | Remote byte address |
| vme_write | input | 1 | Remote cycle is a write |
| vme_tas | input | 1 | Remote cycle is an indivisible test-and-set |
| vme_wdata | input | 8 | Remote write data |
| vme_rdata | output | 8 | Remote read data, valid while vme_ack is high |
| vme_ack | output | 1 | Remote cycle acknowledge, held until the strobe drops |
| irq5_o | output | 1 | Level-5 interrupt request to the local CPU |
| berr_o | output | 1 | One-clock bus-error pulse from the watchdog |

## Verification
The bench uses addresses that sit just outside the alias range: an even byte, the first byte past 8 KB, a wrong base, and a disabled window. A loose decoder would acknowledge one of these. The bench also sends remote writes that carry clear bits and a zero pending flag. A port that copied write data into the register would alter the CPU's view of the byte or drop the interrupt.

Test-and-set is run twice in a row, so a design that returned the new value instead of the old one would show 0xCA on the first access. A CPU clear is placed in the same clock as a remote set, which catches a design that lets the CPU win. The watchdog is held just short of its limit and then past it. An off-by-far count, a repeated pulse, or a pulse while disabled each changes the number of bus errors observed.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned B_PEND  = 7;
    localparam int unsigned B_WINEN = 6;
    localparam int unsigned B_WDEN  = 5;
    localparam int unsigned B_SYSC  = 4;
    localparam int unsigned BASE_W  = 4;

    typedef enum logic [2:0] {
        V_IDLE  = 3'd0,
        V_READ  = 3'd1,
        V_WRITE = 3'd2,
        V_TAS   = 3'd3,
        V_HOLD  = 3'd4,
        V_SKIP  = 3'd5
    } vme_state_t;

    typedef enum logic [1:0] {
        T_IDLE  = 2'd0,
        T_RUN   = 2'd1,
        T_FIRED = 2'd2
    } wd_state_t;

    function automatic logic [BYTE_W-1:0] hw_reset_val(input logic slot1);
        logic [BYTE_W-1:0] v;
        v         = '0;
        v[B_SYSC] = slot1;
        return v;
    endfunction

    function automatic logic [BYTE_W-1:0] sw_reset_val(input logic slot1,
                                                       input logic [BYTE_W-1:0] preset);
        logic [BYTE_W-1:0] v;
        v                = '0;
        v[B_WINEN]       = preset[B_WINEN];
        v[B_WDEN]        = slot1;
        v[B_SYSC]        = slot1;
        v[BASE_W-1:0]    = preset[BASE_W-1:0];
        return v;
    endfunction

endpackage

// File: rtl/mbox_addr_dec.sv
module mbox_addr_dec
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned ALIAS_BITS = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] ctl_q,
    output logic              hit
);
    localparam int unsigned MID_HI = ADDR_W - BASE_W - 1;
    localparam int unsigned MID_W  = MID_HI - ALIAS_BITS + 1;

    logic base_ok;
    logic mid_zero;
    logic odd_ok;

    assign base_ok = (addr[ADDR_W-1 -: BASE_W] == ctl_q[BASE_W-1:0]);

    generate
        if (MID_W > 0) begin : g_mid
            assign mid_zero = (addr[MID_HI:ALIAS_BITS] == '0);
        end else begin : g_nomid
            assign mid_zero = 1'b1;
        end
    endgenerate

    assign odd_ok = addr[0];
    assign hit    = ctl_q[B_WINEN] & base_ok & mid_zero & odd_ok;

    logic unused_addr;
    assign unused_addr = ^{addr[ALIAS_BITS-1:1], ctl_q[B_PEND:B_SYSC]};

endmodule

// File: rtl/mbox_vme_fsm.sv
module mbox_vme_fsm
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              hit,
    input  logic              is_write,
    input  logic              is_tas,
    input  logic              wdata_pend,
    input  logic [BYTE_W-1:0] ctl_q,
    output logic              stb_rise,
    output logic              ack,
    output logic              set_pend,
    output logic [BYTE_W-1:0] rdata
);
    vme_state_t state_q;
    vme_state_t state_d;
    logic       stb_q;
    logic       capture;

    assign stb_rise = stb & ~stb_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            V_IDLE: begin
                if (stb_rise) begin
                    if (!hit)          state_d = V_SKIP;
                    else if (is_tas)   state_d = V_TAS;
                    else if (is_write) state_d = V_WRITE;
                    else               state_d = V_READ;
                end
            end
            V_READ:  state_d = V_HOLD;
            V_WRITE: state_d = V_HOLD;
            V_TAS:   state_d = V_HOLD;
            V_HOLD:  if (!stb) state_d = V_IDLE;
            V_SKIP:  if (!stb) state_d = V_IDLE;
            default: state_d = V_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= V_IDLE;
            stb_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            stb_q   <= stb;
        end
    end

    always_comb begin
        ack      = 1'b0;
        set_pend = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            V_READ:  capture = 1'b1;
            V_WRITE: set_pend = wdata_pend;
            V_TAS: begin
                capture  = 1'b1;
                set_pend = 1'b1;
            end
            V_HOLD:  ack = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata <= '0;
        else if (capture) rdata <= ctl_q;
    end

endmodule

// File: rtl/mbox_ctl_core.sv
module mbox_ctl_core
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              slot1,
    input  logic [BYTE_W-1:0] preset,
    input  logic              cpu_wr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic              vme_set,
    output logic [BYTE_W-1:0] ctl_q
);
    logic [BYTE_W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (cpu_wr)  ctl_d = cpu_wdata;
        if (vme_set) ctl_d[B_PEND] = 1'b1;
        if (sw_rst)  ctl_d = sw_reset_val(slot1, preset);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= hw_reset_val(slot1);
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/mbox_bus_watch.sv
module mbox_bus_watch
    import mbox_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned TIMEOUT_US = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic stb,
    input  logic stb_rise,
    input  logic ack,
    output logic berr
);
    localparam int unsigned LIMIT = (CLK_HZ / 1_000_000) * TIMEOUT_US;
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    wd_state_t        state_q;
    wd_state_t        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             fire;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        unique case (state_q)
            T_IDLE: ;
            T_RUN: begin
                if (!enable || !stb || ack) begin
                    state_d = T_IDLE;
                end else if (cnt_q == LAST) begin
                    state_d = T_FIRED;
                    fire    = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            T_FIRED: if (!stb) state_d = T_IDLE;
            default: state_d = T_IDLE;
        endcase
        if (stb_rise && enable) begin
            state_d = T_RUN;
            cnt_d   = '0;
            fire    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
            cnt_q   <= '0;
            berr    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            berr    <= fire;
        end
    end

endmodule

// File: rtl/mbox_ctl_reg.sv
module mbox_ctl_reg
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned ALIAS_BITS = 13,
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned TIMEOUT_US = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              slot1_i,
    input  logic [7:0]        preset_i,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              vme_stb,
    input  logic [ADDR_W-1:0] vme_addr,
    input  logic              vme_write,
    input  logic              vme_tas,
    input  logic [7:0]        vme_wdata,
    output logic [7:0]        vme_rdata,
    output logic              vme_ack,
    output logic              irq5_o,
    output logic              berr_o
);
    logic [BYTE_W-1:0] ctl_q;
    logic              hit_w;
    logic              stb_rise_w;
    logic              vme_set_w;

    mbox_addr_dec #(
        .ADDR_W    (ADDR_W),
        .ALIAS_BITS(ALIAS_BITS)
    ) u_dec (
        .addr (vme_addr),
        .ctl_q(ctl_q),
        .hit  (hit_w)
    );

    mbox_vme_fsm u_vme (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (vme_stb),
        .hit       (hit_w),
        .is_write  (vme_write),
        .is_tas    (vme_tas),
        .wdata_pend(vme_wdata[B_PEND]),
        .ctl_q     (ctl_q),
        .stb_rise  (stb_rise_w),
        .ack       (vme_ack),
        .set_pend  (vme_set_w),
        .rdata     (vme_rdata)
    );

    mbox_ctl_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst   (sw_rst),
        .slot1    (slot1_i),
        .preset   (preset_i),
        .cpu_wr   (cpu_wr),
        .cpu_wdata(cpu_wdata),
        .vme_set  (vme_set_w),
        .ctl_q    (ctl_q)
    );

    mbox_bus_watch #(
        .CLK_HZ    (CLK_HZ),
        .TIMEOUT_US(TIMEOUT_US)
    ) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ctl_q[B_WDEN]),
        .stb     (vme_stb),
        .stb_rise(stb_rise_w),
        .ack     (vme_ack),
        .berr    (berr_o)
    );

    assign cpu_rdata = ctl_q;
    assign irq5_o    = ctl_q[B_PEND];

    logic unused_in;
    assign unused_in = ^{vme_wdata[6:0]};

endmodule

// File: rtl/mbox_ctl_chk.sv
module mbox_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_rst,
    input logic       cpu_wr,
    input logic [7:0] cpu_wdata,
    input logic [7:0] cpu_rdata,
    input logic       vme_set,
    input logic       vme_ack,
    input logic       irq5_o,
    input logic       berr_o
);
    // R4: the interrupt only rises after a remote set or a CPU write of bit 7
    assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq5_o) |-> ($past(vme_set) || ($past(cpu_wr) && $past(cpu_wdata[7]))));

    // R5: an acknowledge starts only if the window was enabled at decode time
    assert_ack_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vme_ack) |-> $past(cpu_rdata[6], 2));

    // R6: without CPU write or software reset, bits 6..0 never change
    assert_low_bits_protected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cpu_wr) && !$past(sw_rst)) |-> (cpu_rdata[6:0] == $past(cpu_rdata[6:0])));

    // R6: the remote side never clears the pending flag
    assert_no_remote_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cpu_wr) && !$past(sw_rst) && $past(cpu_rdata[7])) |-> cpu_rdata[7]);

    // R9: a remote set wins over a simultaneous CPU clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vme_set) && !$past(sw_rst)) |-> cpu_rdata[7]);

    // R10: a bus error lasts one clock
    assert_berr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        berr_o |=> !berr_o);

    // R10: a bus error needs the watchdog enabled
    assert_berr_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        berr_o |-> $past(cpu_rdata[5]));

endmodule

bind mbox_ctl_reg mbox_ctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_rst   (sw_rst),
    .cpu_wr   (cpu_wr),
    .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata),
    .vme_set  (vme_set_w),
    .vme_ack  (vme_ack),
    .irq5_o   (irq5_o),
    .berr_o   (berr_o)
);

// File: tb/mbox_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module mbox_ctl_reg_tb_top;

    localparam int LIMIT = 50 * 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        slot1_i = 1'b0;
    logic [7:0]  preset_i = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic        vme_stb = 1'b0;
    logic [23:0] vme_addr = 24'h0;
    logic        vme_write = 1'b0;
    logic        vme_tas = 1'b0;
    logic [7:0]  vme_wdata = 8'h00;
    logic [7:0]  vme_rdata;
    logic        vme_ack;
    logic        irq5_o;
    logic        berr_o;

    always #10 clk = ~clk;

    mbox_ctl_reg dut_i (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .slot1_i(slot1_i),
        .preset_i(preset_i), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .vme_stb(vme_stb), .vme_addr(vme_addr),
        .vme_write(vme_write), .vme_tas(vme_tas), .vme_wdata(vme_wdata),
        .vme_rdata(vme_rdata), .vme_ack(vme_ack), .irq5_o(irq5_o),
        .berr_o(berr_o)
    );

    typedef struct {
        int         src;
        logic [15:0] exp;
        string      req;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     sample_ev;
    int       vectors = 0;
    int       miscompares = 0;
    int       berr_cnt = 0;
    logic [7:0] last_rdata = 8'h00;
    logic       last_ack = 1'b0;
    bit         done = 1'b0;

    always @(negedge clk) if (rst_n && berr_o) berr_cnt++;

    // monitor: pop the expected item and compare with what the design shows
    always @(sample_ev) begin
        while (sb_q.size() > 0) begin
            sb_item_t   it;
            logic [15:0] obs;
            it = sb_q.pop_front();
            case (it.src)
                0: obs = {8'h00, cpu_rdata};
                1: obs = {8'h00, last_rdata};
                2: obs = {15'h0, irq5_o};
                3: obs = {15'h0, last_ack};
                default: obs = 16'(berr_cnt);
            endcase
            vectors++;
            if (obs !== it.exp) begin
                miscompares++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.req, obs, it.exp);
            end
        end
    end

    task automatic expect_val(input int src, input logic [15:0] exp, input string req);
        sb_item_t it;
        it.src = src;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic cpu_write(input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1;
        cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic soft_reset(input logic s1, input logic [7:0] p);
        @(negedge clk);
        slot1_i = s1;
        preset_i = p;
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
    endtask

    task automatic hard_reset(input logic s1);
        @(negedge clk);
        rst_n = 1'b0;
        slot1_i = s1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic vme_cycle(input logic [23:0] a, input logic wr, input logic tas,
                             input logic [7:0] d, input int hold);
        @(negedge clk);
        vme_addr = a;
        vme_write = wr;
        vme_tas = tas;
        vme_wdata = d;
        vme_stb = 1'b1;
        last_ack = 1'b0;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (vme_ack) begin
                last_ack = 1'b1;
                last_rdata = vme_rdata;
                break;
            end
        end
        vme_stb = 1'b0;
        vme_write = 1'b0;
        vme_tas = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1 hardware reset values
        hard_reset(1'b1);
        expect_val(0, 16'h10, "R1 slot1 hw reset");
        expect_val(2, 16'h0, "R4 irq low after reset");
        hard_reset(1'b0);
        expect_val(0, 16'h00, "R1 other-slot hw reset");

        // R2 software reset values
        cpu_write(8'h80);
        soft_reset(1'b0, 8'hFF);
        expect_val(0, 16'h4F, "R2 sw reset slot0 preset FF");
        soft_reset(1'b1, 8'h00);
        expect_val(0, 16'h30, "R2 sw reset slot1 preset 00");
        cpu_write(8'h80);
        soft_reset(1'b1, 8'hC5);
        expect_val(0, 16'h75, "R2 sw reset clears pending, loads preset");

        // R3 CPU write
        cpu_write(8'h4A);
        expect_val(0, 16'h4A, "R3 cpu write 4A");

        // R7 reads at aliases
        vme_cycle(24'hA00001, 1'b0, 1'b0, 8'h00, 20);
        expect_val(3, 16'h1, "R5 ack at first odd byte");
        expect_val(1, 16'h4A, "R7 read at A00001");
        vme_cycle(24'hA01FFF, 1'b0, 1'b0, 8'h00, 20);
        expect_val(1, 16'h4A, "R7 read at last alias A01FFF");
        vme_cycle(24'hA00ABB, 1'b0, 1'b0, 8'h00, 20);
        expect_val(1, 16'h4A, "R7 read at mid alias A00ABB");

        // R5 misses
        vme_cycle(24'hA00002, 1'b0, 1'b0, 8'h00, 20);
        expect_val(3, 16'h0, "R5 even address no ack");
        vme_cycle(24'hA02001, 1'b0, 1'b0, 8'h00, 20);
        expect_val(3, 16'h0, "R5 beyond 8KB no ack");
        vme_cycle(24'hB00001, 1'b0, 1'b0, 8'h00, 20);
        expect_val(3, 16'h0, "R5 wrong base no ack");
        cpu_write(8'h0A);
        vme_cycle(24'hA00001, 1'b0, 1'b0, 8'h00, 20);
        expect_val(3, 16'h0, "R5 window disabled no ack");
        cpu_write(8'h4A);

        // R6 write protection
        vme_cycle(24'hA00001, 1'b1, 1'b0, 8'h7F, 20);
        expect_val(3, 16'h1, "R6 write acked");
        expect_val(0, 16'h4A, "R6 low bits ignore remote write");
        expect_val(2, 16'h0, "R4 irq stays low");
        vme_cycle(24'hA00001, 1'b1, 1'b0, 8'h80, 20);
        expect_val(0, 16'hCA, "R6 remote sets pending");
        expect_val(2, 16'h1, "R4 irq high while pending");
        vme_cycle(24'hA00003, 1'b1, 1'b0, 8'h00, 20);
        expect_val(0, 16'hCA, "R6 remote cannot clear pending");
        cpu_write(8'h4A);
        expect_val(2, 16'h0, "R4 irq low after cpu clear");

        // R8 test-and-set
        vme_cycle(24'hA00005, 1'b1, 1'b1, 8'h00, 20);
        expect_val(1, 16'h4A, "R8 tas returns old byte");
        expect_val(0, 16'hCA, "R8 tas sets pending");
        vme_cycle(24'hA00005, 1'b1, 1'b1, 8'h00, 20);
        expect_val(1, 16'hCA, "R8 second tas sees flag taken");

        // R9 same-cycle collision
        cpu_write(8'h4A);
        @(negedge clk);
        vme_addr = 24'hA00001;
        vme_write = 1'b1;
        vme_tas = 1'b0;
        vme_wdata = 8'h80;
        vme_stb = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b1;
        cpu_wdata = 8'h0A;
        @(negedge clk);
        cpu_wr = 1'b0;
        repeat (3) @(negedge clk);
        vme_stb = 1'b0;
        vme_write = 1'b0;
        repeat (2) @(negedge clk);
        expect_val(0, 16'h8A, "R9 remote set wins over cpu clear");

        // R10 watchdog
        cpu_write(8'h6A);
        berr_cnt = 0;
        vme_cycle(24'hA00002, 1'b0, 1'b0, 8'h00, LIMIT - 20);
        expect_val(4, 16'd0, "R10 no error before limit");
        vme_cycle(24'hA00002, 1'b0, 1'b0, 8'h00, LIMIT + 40);
        expect_val(4, 16'd1, "R10 one error past limit");
        vme_cycle(24'hA00001, 1'b0, 1'b0, 8'h00, 20);
        expect_val(4, 16'd1, "R10 acked cycle no error");
        cpu_write(8'h4A);
        vme_cycle(24'hA00002, 1'b0, 1'b0, 8'h00, LIMIT + 40);
        expect_val(4, 16'd1, "R10 no error while disabled");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule